// File: doc/BRIEF.md
# Prefixed opcode fetch and classification unit

This unit sits at the front of a Z80-style instruction pipeline. It reads instruction bytes, one per cycle, from a combinational memory read port addressed by its own program counter. It recognises the four prefix bytes (CB, ED, DD, FD) and turns every instruction into one index in a flat 11-bit decode space. The execution stage uses that index to select behaviour.

For the doubly-prefixed indexed forms (DD CB d op and FD CB d op) the unit consumes the signed displacement byte that comes before the final opcode byte. It adds the sign-extended displacement to the chosen index register and presents the effective address with the index. The unit also keeps the memory refresh counter. The low seven bits of that counter advance on opcode fetches only, and the top bit is left alone.

A decoded instruction is offered with a valid/ready handshake and held until it is taken. Immediate operand bytes that follow an opcode (n, nn) are left for the next stage to fetch. A redirect input loads a new program counter and abandons any partially fetched instruction.

Top module: `opcode_prefix_decoder`

## Requirements
- R1: A first byte that is none of CB, ED, DD, FD gives index = that byte (0..255), select = 0, plain = 0, effective address = 0. It consumes one byte and adds 1 to the refresh count.
- R2: CB followed by op gives index 256+op, and ED followed by op gives index 512+op. Each consumes two bytes, adds 2 to the refresh count, and gives select = 0.
- R3: DD or FD followed by an op that uses H, L or (HL) gives index 768+op with select = 1 (IX), or 1280+op with select = 2 (IY). Ops that use H, L or (HL) are: 0x40..0x7F (except 0x76) with either register field in 4..6; 0x80..0xBF with source field in 4..6; 0x24..0x26, 0x2C..0x2E, 0x34..0x36, 0x09, 0x19, 0x21..0x23, 0x29, 0x2A, 0x2B, 0x39; and 0xE1, 0xE3, 0xE5, 0xE9, 0xF9.
- R4: DD or FD followed by an op that does not use H/L gives index = op, plain = 1 and select = 0, and adds 2 to the refresh count.
- R5: DD CB d op gives index 1024+op with select = 1, and FD CB d op gives index 1024+op with select = 2. The effective address is IX (or IY) plus d sign-extended, modulo 2^16. The sequence consumes four bytes, and only the DD/FD byte and the CB byte add to the refresh count (total 2).
- R6: The refresh low seven bits wrap modulo 128 and bit 7 is never changed by a fetch. A refresh write loads all 8 bits and takes priority over a fetch increment in the same cycle.
- R7: The program counter advances by one for each byte consumed and wraps from 0xFFFF to 0x0000.
- R8: ED followed by an op outside {0x40..0x7F except 0x77 and 0x7F, 0xA0..0xA3, 0xA8..0xAB, 0xB0..0xB3, 0xB8..0xBB} raises invalid_op for exactly one cycle, the first cycle of valid. The index is still 512+op.
- R9: While valid is high and ready is low, the index, select, plain and effective address stay stable and no byte is read. The cycle after acceptance starts the next fetch.
- R10: A redirect loads the program counter, drops valid and discards any partial prefix sequence. No refresh increment happens in the redirect cycle.
- R11: During reset, valid is 0, invalid_op is 0, the program counter is 0 and the refresh count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect | input | 1 | Load redirect_pc and restart fetching |
| redirect_pc | input | 16 | New program counter |
| rfsh_wr | input | 1 | Load the refresh counter |
| rfsh_wr_val | input | 8 | Value for the refresh counter |
| ix_val | input | 16 | Current IX value |
| iy_val | input | 16 | Current IY value |
| mem_rd | output | 1 | A byte is consumed this cycle |
| mem_addr | output | 16 | Read address (program counter) |
| mem_rdata | input | 8 | Byte at mem_addr, same cycle |
| dec_valid | output | 1 | Decoded instruction offered |
| dec_ready | input | 1 | Consumer takes the decoded instruction |
| dec_index | output | 11 | Flat decode index |
| dec_sel | output | 2 | Index register: 0 none, 1 IX, 2 IY |
| dec_plain | output | 1 | DD/FD prefix fell back to the plain opcode |
| eff_addr | output | 16 | Indexed effective address (0 when unused) |
| invalid_op | output | 1 | One-cycle pulse for an undefined ED opcode |
| pc_out | output | 16 | Current program counter |
| rfsh_low | output | 7 | Refresh counter, counting bits |
| rfsh_hi | output | 1 | Refresh counter, held bit 7 |

## Verification
The assertions check on every cycle that an offered result stays still under backpressure and that no byte is read while one is held. They also check that invalid_op is a lone pulse that coincides with an ED-family result, and that a redirect drops valid. On every cycle they check that the program counter steps by exactly one per consumed byte, that refresh bit 7 only changes on a write, and that the low bits step by one per fetch. Only the bench's scenarios show the mapping itself: the index for each prefix family, the split between the H/L-using and plain DD/FD opcodes, the sign-extended effective address with carry and wraparound, the per-instruction refresh totals, and the abandoning of a half-fetched sequence.

// File: rtl/opdec_pkg.sv
// Package: shared constants, types and opcode predicates for the
// prefixed opcode decoder. Assumes 8-bit opcodes and an 11-bit index.
package opdec_pkg;

    localparam int unsigned OP_W   = 8;
    localparam int unsigned IDX_W  = 11;

    localparam int unsigned BASE_CB  = 256;
    localparam int unsigned BASE_ED  = 512;
    localparam int unsigned BASE_DD  = 768;
    localparam int unsigned BASE_XCB = 1024;
    localparam int unsigned BASE_FD  = 1280;

    localparam logic [7:0] BYTE_CB = 8'hCB;
    localparam logic [7:0] BYTE_ED = 8'hED;
    localparam logic [7:0] BYTE_DD = 8'hDD;
    localparam logic [7:0] BYTE_FD = 8'hFD;

    typedef enum logic [2:0] {
        ST_OP1  = 3'd0,
        ST_OP2  = 3'd1,
        ST_DISP = 3'd2,
        ST_OP3  = 3'd3,
        ST_HOLD = 3'd4
    } fetch_st_e;

    typedef enum logic [1:0] {
        FAM_CB = 2'd0,
        FAM_ED = 2'd1,
        FAM_DD = 2'd2,
        FAM_FD = 2'd3
    } family_e;

    localparam logic [1:0] IREG_NONE = 2'd0;
    localparam logic [1:0] IREG_X    = 2'd1;
    localparam logic [1:0] IREG_Y    = 2'd2;

    // True when a byte opens a prefixed sequence.
    function automatic logic is_prefix(input logic [7:0] b);
        return (b == BYTE_CB) || (b == BYTE_ED) || (b == BYTE_DD) || (b == BYTE_FD);
    endfunction

    // Prefix byte to family code.
    function automatic family_e family_of(input logic [7:0] b);
        family_e f;
        case (b)
            BYTE_CB: f = FAM_CB;
            BYTE_ED: f = FAM_ED;
            BYTE_DD: f = FAM_DD;
            default: f = FAM_FD;
        endcase
        return f;
    endfunction

    // True when an unprefixed opcode names H, L or (HL).
    function automatic logic uses_hl(input logic [7:0] op);
        logic hit;
        logic src_hl;
        logic dst_hl;
        src_hl = (op[2:0] == 3'd4) || (op[2:0] == 3'd5) || (op[2:0] == 3'd6);
        dst_hl = (op[5:3] == 3'd4) || (op[5:3] == 3'd5) || (op[5:3] == 3'd6);
        case (op[7:6])
            2'b01:   hit = (op != 8'h76) && (src_hl || dst_hl);
            2'b10:   hit = src_hl;
            2'b00:   hit = (src_hl && dst_hl) ||
                           (op == 8'h09) || (op == 8'h19) || (op == 8'h21) ||
                           (op == 8'h22) || (op == 8'h23) || (op == 8'h29) ||
                           (op == 8'h2A) || (op == 8'h2B) || (op == 8'h39);
            default: hit = (op == 8'hE1) || (op == 8'hE3) || (op == 8'hE5) ||
                           (op == 8'hE9) || (op == 8'hF9);
        endcase
        return hit;
    endfunction

    // True when an ED-prefixed opcode has a defined meaning.
    function automatic logic ed_known(input logic [7:0] op);
        return ((op[7:6] == 2'b01) && (op != 8'h77) && (op != 8'h7F)) ||
               ((op[7:5] == 3'b101) && !op[2]);
    endfunction

endpackage

// File: rtl/opdec_classify.sv
// Module: opdec_classify
// Maps the byte after a prefix to the flat index. Purely combinational.
// Assumes fam names the prefix already consumed.
module opdec_classify
    import opdec_pkg::*;
#(
    parameter int unsigned IW = IDX_W
) (
    input  family_e       fam,
    input  logic [7:0]    op,
    output logic [IW-1:0] index,
    output logic [1:0]    sel,
    output logic          plain,
    output logic          undef,
    output logic          chain
);

    logic [IW-1:0] op_w;
    assign op_w = IW'(op);

    // Purpose: pick the family offset, or fall back to the plain opcode.
    always_comb begin
        index = op_w;
        sel   = IREG_NONE;
        plain = 1'b0;
        undef = 1'b0;
        chain = 1'b0;
        case (fam)
            FAM_CB: index = IW'(BASE_CB) + op_w;
            FAM_ED: begin
                index = IW'(BASE_ED) + op_w;
                undef = !ed_known(op);
            end
            FAM_DD, FAM_FD: begin
                if (op == BYTE_CB) begin
                    chain = 1'b1;
                end else if (uses_hl(op)) begin
                    index = (fam == FAM_DD) ? IW'(BASE_DD) + op_w : IW'(BASE_FD) + op_w;
                    sel   = (fam == FAM_DD) ? IREG_X : IREG_Y;
                end else begin
                    plain = 1'b1;
                end
            end
            default: index = op_w;
        endcase
    end

endmodule

// File: rtl/opdec_pc.sv
// Module: opdec_pc
// Program counter: loads on redirect, otherwise steps by one per
// consumed byte, wrapping at 2^AW. Synchronous active-low reset to 0.
module opdec_pc #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          bump,
    output logic [AW-1:0] q
);

    // Purpose: hold the fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (bump) q <= q + 1'b1;
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !load) |=> (q == $past(q) + 1'b1)); // R7

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(load_val))); // R10

endmodule

// File: rtl/opdec_refresh.sv
// Module: opdec_refresh
// Refresh counter: RW counting bits that wrap, plus one held top bit.
// A write loads all bits and beats an increment in the same cycle.
module opdec_refresh #(
    parameter int unsigned RW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [RW:0]   wr_val,
    input  logic          bump,
    output logic [RW-1:0] low,
    output logic          hi
);

    // Purpose: count opcode fetches in the low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)    low <= '0;
        else if (wr)   low <= wr_val[RW-1:0];
        else if (bump) low <= low + 1'b1;
    end

    // Purpose: keep the top bit apart from the count.
    always_ff @(posedge clk) begin
        if (!rst_n)  hi <= 1'b0;
        else if (wr) hi <= wr_val[RW];
    end

    AST_RFSH_TOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> (hi == $past(hi))); // R6

    AST_RFSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !wr) |=> (low == RW'($past(low) + 1'b1))); // R6

endmodule

// File: rtl/opcode_prefix_decoder.sv
// Module: opcode_prefix_decoder
// Fetches one byte per cycle at the program counter, walks prefix
// sequences and offers a flat decode index with valid/ready.
// Assumes mem_rdata is valid in the same cycle as mem_addr.
module opcode_prefix_decoder
    import opdec_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned RFSH_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_pc,
    input  logic              rfsh_wr,
    input  logic [RFSH_W:0]   rfsh_wr_val,
    input  logic [ADDR_W-1:0] ix_val,
    input  logic [ADDR_W-1:0] iy_val,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [IDX_W-1:0]  dec_index,
    output logic [1:0]        dec_sel,
    output logic              dec_plain,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              invalid_op,
    output logic [ADDR_W-1:0] pc_out,
    output logic [RFSH_W-1:0] rfsh_low,
    output logic              rfsh_hi
);

    localparam int unsigned SEXT_W = ADDR_W - OP_W;

    fetch_st_e            state_q;
    family_e              fam_q;
    logic [IDX_W-1:0]     idx_q;
    logic [1:0]           sel_q;
    logic                 plain_q;
    logic [ADDR_W-1:0]    eff_q;
    logic                 inv_q;
    logic [ADDR_W-1:0]    pc_q;

    logic [IDX_W-1:0]     cls_index;
    logic [1:0]           cls_sel;
    logic                 cls_plain;
    logic                 cls_undef;
    logic                 cls_chain;
    logic                 opcode_fetch;
    logic [ADDR_W-1:0]    idx_base;

    // Purpose: a byte is consumed in every fetch state.
    always_comb begin
        mem_rd = (state_q == ST_OP1) || (state_q == ST_OP2) ||
                 (state_q == ST_DISP) || (state_q == ST_OP3);
    end

    // Purpose: only the first opcode byte and the byte after a prefix refresh.
    always_comb begin
        opcode_fetch = ((state_q == ST_OP1) || (state_q == ST_OP2)) && !redirect;
        idx_base     = (fam_q == FAM_DD) ? ix_val : iy_val;
    end

    opdec_classify #(.IW(IDX_W)) u_classify (
        .fam   (fam_q),
        .op    (mem_rdata),
        .index (cls_index),
        .sel   (cls_sel),
        .plain (cls_plain),
        .undef (cls_undef),
        .chain (cls_chain)
    );

    opdec_pc #(.AW(ADDR_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (redirect),
        .load_val (redirect_pc),
        .bump     (mem_rd),
        .q        (pc_q)
    );

    opdec_refresh #(.RW(RFSH_W)) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (rfsh_wr),
        .wr_val (rfsh_wr_val),
        .bump   (opcode_fetch),
        .low    (rfsh_low),
        .hi     (rfsh_hi)
    );

    // Purpose: sequence the fetch states and capture the decoded result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OP1;
            fam_q   <= FAM_CB;
            idx_q   <= '0;
            sel_q   <= IREG_NONE;
            plain_q <= 1'b0;
            eff_q   <= '0;
            inv_q   <= 1'b0;
        end else begin
            inv_q <= 1'b0;
            if (redirect) begin
                state_q <= ST_OP1;
            end else begin
                case (state_q)
                    ST_OP1: begin
                        if (is_prefix(mem_rdata)) begin
                            fam_q   <= family_of(mem_rdata);
                            state_q <= ST_OP2;
                        end else begin
                            idx_q   <= IDX_W'(mem_rdata);
                            sel_q   <= IREG_NONE;
                            plain_q <= 1'b0;
                            eff_q   <= '0;
                            state_q <= ST_HOLD;
                        end
                    end
                    ST_OP2: begin
                        if (cls_chain) begin
                            sel_q   <= (fam_q == FAM_DD) ? IREG_X : IREG_Y;
                            plain_q <= 1'b0;
                            state_q <= ST_DISP;
                        end else begin
                            idx_q   <= cls_index;
                            sel_q   <= cls_sel;
                            plain_q <= cls_plain;
                            eff_q   <= '0;
                            inv_q   <= cls_undef;
                            state_q <= ST_HOLD;
                        end
                    end
                    ST_DISP: begin
                        eff_q   <= idx_base + {{SEXT_W{mem_rdata[7]}}, mem_rdata};
                        state_q <= ST_OP3;
                    end
                    ST_OP3: begin
                        idx_q   <= IDX_W'(BASE_XCB) + IDX_W'(mem_rdata);
                        state_q <= ST_HOLD;
                    end
                    ST_HOLD: begin
                        if (dec_ready) state_q <= ST_OP1;
                    end
                    default: state_q <= ST_OP1;
                endcase
            end
        end
    end

    assign mem_addr   = pc_q;
    assign pc_out     = pc_q;
    assign dec_valid  = (state_q == ST_HOLD);
    assign dec_index  = idx_q;
    assign dec_sel    = sel_q;
    assign dec_plain  = plain_q;
    assign eff_addr   = eff_q;
    assign invalid_op = inv_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready && !redirect) |=>
        (dec_valid && $stable(dec_index) && $stable(dec_sel) &&
         $stable(dec_plain) && $stable(eff_addr))); // R9

    AST_NO_READ_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !mem_rd); // R9

    AST_INVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_op |=> !invalid_op); // R8

    AST_INVALID_ED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_op |-> (dec_valid && (dec_index[IDX_W-1:8] == 3'b010))); // R8

    AST_REDIRECT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !dec_valid); // R10

    AST_INDEXED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_plain) |-> (dec_sel == IREG_NONE) && (dec_index[IDX_W-1:8] == 3'b000)); // R4

endmodule

// File: tb/opcode_prefix_decoder_bench.sv
`timescale 1ns/1ps
module opcode_prefix_decoder_bench;

    typedef struct packed {
        logic [31:0] bytes;
        logic [7:0]  base;
        logic [10:0] idx;
        logic [1:0]  sel;
        logic        plain;
        logic        inv;
        logic [2:0]  len;
        logic [1:0]  rinc;
        logic [15:0] eff;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h00000000, 8'h10, 11'h000, 2'd0, 1'b0, 1'b0, 3'd1, 2'd1, 16'h0000}, // R1
        '{32'h3E000000, 8'h18, 11'h03E, 2'd0, 1'b0, 1'b0, 3'd1, 2'd1, 16'h0000}, // R1
        '{32'hCB110000, 8'h20, 11'h111, 2'd0, 1'b0, 1'b0, 3'd2, 2'd2, 16'h0000}, // R2
        '{32'hEDB00000, 8'h28, 11'h2B0, 2'd0, 1'b0, 1'b0, 3'd2, 2'd2, 16'h0000}, // R2
        '{32'hED000000, 8'h30, 11'h200, 2'd0, 1'b0, 1'b1, 3'd2, 2'd2, 16'h0000}, // R8
        '{32'hDD210000, 8'h38, 11'h321, 2'd1, 1'b0, 1'b0, 3'd2, 2'd2, 16'h0000}, // R3
        '{32'hFD7E0000, 8'h40, 11'h57E, 2'd2, 1'b0, 1'b0, 3'd2, 2'd2, 16'h0000}, // R3
        '{32'hDD780000, 8'h48, 11'h078, 2'd0, 1'b1, 1'b0, 3'd2, 2'd2, 16'h0000}, // R4
        '{32'hFDC30000, 8'h50, 11'h0C3, 2'd0, 1'b1, 1'b0, 3'd2, 2'd2, 16'h0000}, // R4
        '{32'hDDCB0546, 8'h58, 11'h446, 2'd1, 1'b0, 1'b0, 3'd4, 2'd2, 16'h1005}, // R5
        '{32'hFDCB03FE, 8'h60, 11'h4FE, 2'd2, 1'b0, 1'b0, 3'd4, 2'd2, 16'h0001}, // R5
        '{32'hDDCB8006, 8'h68, 11'h406, 2'd1, 1'b0, 1'b0, 3'd4, 2'd2, 16'h0F80}, // R5
        '{32'hED770000, 8'h70, 11'h277, 2'd0, 1'b0, 1'b1, 3'd2, 2'd2, 16'h0000}, // R8
        '{32'hDD240000, 8'h78, 11'h324, 2'd1, 1'b0, 1'b0, 3'd2, 2'd2, 16'h0000}  // R3
    };

    logic        clk;
    logic        rst_n;
    logic        redirect;
    logic [15:0] redirect_pc;
    logic        rfsh_wr;
    logic [7:0]  rfsh_wr_val;
    logic [15:0] ix_val;
    logic [15:0] iy_val;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        dec_valid;
    logic        dec_ready;
    logic [10:0] dec_index;
    logic [1:0]  dec_sel;
    logic        dec_plain;
    logic [15:0] eff_addr;
    logic        invalid_op;
    logic [15:0] pc_out;
    logic [6:0]  rfsh_low;
    logic        rfsh_hi;

    logic [7:0]  mem [256];
    int          n_checks;
    int          n_bad;
    int          cycles;

    assign mem_rdata = mem[mem_addr[7:0]];

    opcode_prefix_decoder u_opcode_prefix_decoder (
        .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_pc(redirect_pc),
        .rfsh_wr(rfsh_wr), .rfsh_wr_val(rfsh_wr_val), .ix_val(ix_val), .iy_val(iy_val),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_index(dec_index),
        .dec_sel(dec_sel), .dec_plain(dec_plain), .eff_addr(eff_addr),
        .invalid_op(invalid_op), .pc_out(pc_out), .rfsh_low(rfsh_low), .rfsh_hi(rfsh_hi)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic summary_and_end();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks = n_checks + 1;
            n_bad    = n_bad + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycles);
            summary_and_end();
        end
    end

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (got !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", what, got, exp);
        end
    endtask

    // Redirect to addr, optionally writing the refresh counter in the same cycle.
    task automatic go_to(input logic [15:0] addr, input logic wr, input logic [7:0] wv);
        @(negedge clk);
        redirect    = 1'b1;
        redirect_pc = addr;
        rfsh_wr     = wr;
        rfsh_wr_val = wv;
        dec_ready   = 1'b0;
        @(negedge clk);
        redirect = 1'b0;
        rfsh_wr  = 1'b0;
    endtask

    task automatic wait_valid(output logic ok);
        ok = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (dec_valid) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!ok) chk("R9 valid never rose", 32'd0, 32'd1);
    endtask

    task automatic accept();
        dec_ready = 1'b1;
        @(negedge clk);
        dec_ready = 1'b0;
    endtask

    initial begin
        logic        ok;
        logic [7:0]  r0;
        logic [15:0] a0;
        n_checks    = 0;
        n_bad       = 0;
        cycles      = 0;
        rst_n       = 1'b0;
        redirect    = 1'b0;
        redirect_pc = 16'h0;
        rfsh_wr     = 1'b0;
        rfsh_wr_val = 8'h0;
        ix_val      = 16'h1000;
        iy_val      = 16'hFFFE;
        dec_ready   = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;

        // Reset state
        repeat (3) @(negedge clk);
        chk("R11 valid in reset", {31'd0, dec_valid}, 32'd0);
        chk("R11 invalid_op in reset", {31'd0, invalid_op}, 32'd0);
        chk("R11 pc in reset", {16'd0, pc_out}, 32'd0);
        chk("R11 refresh in reset", {24'd0, rfsh_hi, rfsh_low}, 32'd0);
        rst_n = 1'b1;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            for (int b = 0; b < 4; b++)
                mem[VECS[v].base + 8'(b)] = VECS[v].bytes[31 - 8*b -: 8];
            a0 = 16'h3400 | {8'h00, VECS[v].base};
            go_to(a0, 1'b0, 8'h00);
            r0 = {rfsh_hi, rfsh_low};
            wait_valid(ok);
            if (ok) begin
                chk($sformatf("R1-table v%0d index (R2 R3 R4 R5)", v), {21'd0, dec_index}, {21'd0, VECS[v].idx});
                chk($sformatf("R3 v%0d select", v), {30'd0, dec_sel}, {30'd0, VECS[v].sel});
                chk($sformatf("R4 v%0d plain", v), {31'd0, dec_plain}, {31'd0, VECS[v].plain});
                chk($sformatf("R5 v%0d eff_addr", v), {16'd0, eff_addr}, {16'd0, VECS[v].eff});
                chk($sformatf("R7 v%0d pc", v), {16'd0, pc_out}, {16'd0, a0 + 16'(VECS[v].len)});
                chk($sformatf("R6 v%0d refresh", v), {24'd0, rfsh_hi, rfsh_low},
                    {24'd0, r0[7], 7'(r0[6:0] + 7'(VECS[v].rinc))});
                chk($sformatf("R8 v%0d invalid_op", v), {31'd0, invalid_op}, {31'd0, VECS[v].inv});
                @(negedge clk);
                chk($sformatf("R9 v%0d held valid", v), {31'd0, dec_valid}, 32'd1);
                chk($sformatf("R9 v%0d held index", v), {21'd0, dec_index}, {21'd0, VECS[v].idx});
                chk($sformatf("R9 v%0d no refetch", v), {16'd0, pc_out}, {16'd0, a0 + 16'(VECS[v].len)});
                chk($sformatf("R8 v%0d pulse ended", v), {31'd0, invalid_op}, 32'd0);
                accept();
            end
        end

        // Refresh wrap, top bit kept
        mem[8'h80] = 8'h00;
        go_to(16'h0080, 1'b1, 8'hFF);
        chk("R6 write loads all bits", {24'd0, rfsh_hi, rfsh_low}, 32'hFF);
        wait_valid(ok);
        chk("R6 low wraps, top held", {24'd0, rfsh_hi, rfsh_low}, 32'h80);
        accept();
        mem[8'h88] = 8'hCB; mem[8'h89] = 8'h00;
        go_to(16'h0088, 1'b1, 8'h7F);
        wait_valid(ok);
        chk("R6 two fetches across wrap", {24'd0, rfsh_hi, rfsh_low}, 32'h01);
        accept();

        // PC wrap
        mem[8'hFF] = 8'h00;
        go_to(16'hFFFF, 1'b0, 8'h00);
        wait_valid(ok);
        chk("R7 pc wraps one byte", {16'd0, pc_out}, 32'h0000);
        chk("R1 index at wrap", {21'd0, dec_index}, 32'h000);
        accept();
        mem[8'hFF] = 8'hCB; mem[8'h00] = 8'h22;
        go_to(16'hFFFF, 1'b0, 8'h00);
        wait_valid(ok);
        chk("R7 pc wraps mid prefix", {16'd0, pc_out}, 32'h0001);
        chk("R2 index across wrap", {21'd0, dec_index}, 32'h122);
        accept();

        // Redirect abandons a partial DD CB sequence
        mem[8'h90] = 8'hDD; mem[8'h91] = 8'hCB; mem[8'h92] = 8'h05; mem[8'h93] = 8'h46;
        mem[8'hA0] = 8'h3C;
        go_to(16'h0090, 1'b0, 8'h00);
        @(negedge clk);
        chk("R10 partial no valid", {31'd0, dec_valid}, 32'd0);
        go_to(16'h00A0, 1'b0, 8'h00);
        wait_valid(ok);
        chk("R10 index after redirect", {21'd0, dec_index}, 32'h03C);
        chk("R10 select cleared", {30'd0, dec_sel}, 32'd0);
        chk("R10 eff cleared", {16'd0, eff_addr}, 32'd0);
        chk("R10 pc after redirect", {16'd0, pc_out}, 32'h00A1);
        // Redirect while valid drops it
        go_to(16'h00A0, 1'b0, 8'h00);
        chk("R10 valid dropped", {31'd0, dec_valid}, 32'd0);
        wait_valid(ok);
        accept();

        summary_and_end();
    end

endmodule